// File: doc/BRIEF.md
# Cascaded Product-Term Logic Block

This block is one logic block of a programmable-logic fabric. Sixteen cells share one local array. Each cell has five product terms, and each cell's sum result is returned to the device-wide global bus as feedback. The global bus is wide. It carries every pin and the feedback of every cell in the device. A switch matrix therefore narrows it to forty array lines, and each line is picked by its own configurable select.

A cell's sum can grow past five terms in two ways. The first is a one-directional cascade. A cell can donate its whole sum to the next-higher cell. Chains are bounded to groups of eight cells, so one output can collect up to forty terms. The second is a shared return bus. Each cell places one inverted product term on this bus, and every term of every cell in the block can use those sixteen lines as extra array inputs.

All configuration is presented as static input vectors, and the sum outputs are purely combinational.

Top module: `plb_logic_block`

## Requirements
- R1: Array line k equals global bus bit `sel_idx[k]` when `sel_en[k]` is 1. It is 0 when `sel_en[k]` is 0, whatever the index.
- R2: A product term is the AND of the literals it uses. `lt_use`/`rt_use` bit = 1 includes a literal, and the matching `lt_inv`/`rt_inv` bit = 1 takes its complement. A term that uses no literal evaluates to 0.
- R3: Every term of every cell can use all 40 array lines and all 16 return lines. Return line i is bit i of the `rt_*` masks.
- R4: A cell's sum is the OR of its five product terms and of any cascade input it receives.
- R5: When `casc_fwd[i]` is 1, `sum_o[i]` is 0 and cell i's sum is passed to cell i+1.
- R6: A cascade never crosses the boundary between cells 8n-1 and 8n. A sum forwarded by the last cell of an eight-cell group is dropped, so one output gathers at most 40 terms.
- R7: Return line i is the inverse of the AND of the array-line literals of term `ret_sel[i]` of cell i. That term's return-line literals do not enter the return line.
- R8: When `ret_sel[i]` is 5 or more, return line i is held at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| glb_bus | input | 64 | Global bus: pins and feedback of all cells |
| sel_en | input | 40 | Enable per array line |
| sel_idx | input | 40x6 | Global bus index per array line |
| lt_use | input | 16x5x40 | Array-line literal include mask per term |
| lt_inv | input | 16x5x40 | Array-line literal complement mask per term |
| rt_use | input | 16x5x16 | Return-line literal include mask per term |
| rt_inv | input | 16x5x16 | Return-line literal complement mask per term |
| ret_sel | input | 16x3 | Term index each cell places on the return bus |
| casc_fwd | input | 16 | Per cell: forward sum to next cell (1) or emit locally (0) |
| sum_o | output | 16 | Sum results, also the block's feedback to the global bus |

## Verification
The hardest condition to reach from the ports is a full forty-term cascade. In it, eight cells donate in sequence, and any one of forty distinct global bits must surface only at the chain's last output. The stimulus builds this chain with one literal per term and walks a single set bit across all forty lines. A further directed case forwards out of both group-final cells to show that nothing leaks across a boundary. A third case stacks two return hops, so that a return line is computed from a term that itself uses a return literal. This shows that only the array-line part reaches the return bus.

// File: rtl/plb_pkg.sv
package plb_pkg;
  localparam int unsigned PLB_CELLS = 16;
  localparam int unsigned PLB_TERMS = 5;
  localparam int unsigned PLB_LINES = 40;
  localparam int unsigned PLB_GLB_W = 64;
  localparam int unsigned PLB_CHAIN = 8;
endpackage

// File: rtl/plb_switch_matrix.sv
module plb_switch_matrix #(
  parameter int GW    = 64,
  parameter int NLINE = 40,
  parameter int IW    = $clog2(GW)
) (
  input  logic [GW-1:0]              glb_bus,
  input  logic [NLINE-1:0]           sel_en,
  input  logic [NLINE-1:0][IW-1:0]   sel_idx,
  output logic [NLINE-1:0]           lines
);
  // Every index value addresses a real bus bit when the bus width is a power of two.
  localparam bit FULL_RANGE = (GW == (1 << IW));

  for (genvar k = 0; k < NLINE; k++) begin : g_line
    if (FULL_RANGE) begin : g_full
      assign lines[k] = sel_en[k] & glb_bus[sel_idx[k]];
    end else begin : g_part
      assign lines[k] = (sel_en[k] && (int'(sel_idx[k]) < GW)) ? glb_bus[sel_idx[k]] : 1'b0;
    end
  end
endmodule

// File: rtl/plb_cell.sv
module plb_cell #(
  parameter int NLINE = 40,
  parameter int NRET  = 16,
  parameter int NTERM = 5,
  parameter int TW    = 3
) (
  input  logic [NLINE-1:0]             lines,
  input  logic [NRET-1:0]              ret_bus,
  input  logic [NTERM-1:0][NLINE-1:0]  lt_use,
  input  logic [NTERM-1:0][NLINE-1:0]  lt_inv,
  input  logic [NTERM-1:0][NRET-1:0]   rt_use,
  input  logic [NTERM-1:0][NRET-1:0]   rt_inv,
  input  logic [TW-1:0]                ret_sel,
  output logic [NTERM-1:0]             pterm,
  output logic                         ret_o,
  output logic                         local_or
);
  localparam logic [TW:0] TERM_LIMIT = NTERM[TW:0];

  logic [NTERM-1:0] line_part;
  logic [NTERM-1:0] ret_part;
  logic [NTERM-1:0] any_used;

  for (genvar t = 0; t < NTERM; t++) begin : g_term
    // Unused literals contribute a 1 to the AND; a used one passes the (possibly complemented) input.
    assign line_part[t] = &(~lt_use[t] | (lines   ^ lt_inv[t]));
    assign ret_part[t]  = &(~rt_use[t] | (ret_bus ^ rt_inv[t]));
    assign any_used[t]  = (|lt_use[t]) | (|rt_use[t]);
    assign pterm[t]     = any_used[t] & line_part[t] & ret_part[t];
  end

  // The foldback term is taken from the array-line part only, which keeps the return bus loop-free.
  always_comb begin
    if ({1'b0, ret_sel} < TERM_LIMIT) begin
      ret_o = ~line_part[ret_sel];
    end else begin
      ret_o = 1'b1;
    end
  end

  assign local_or = |pterm;
endmodule

// File: rtl/plb_cascade.sv
module plb_cascade #(
  parameter int NCELL = 16,
  parameter int CHAIN = 8
) (
  input  logic [NCELL-1:0] local_or,
  input  logic [NCELL-1:0] casc_fwd,
  output logic [NCELL-1:0] sum_o
);
  logic [NCELL-1:0] cin;
  logic [NCELL-1:0] total;
  logic [NCELL-1:0] carry;
  logic [NCELL-1:0] tail_unused;

  for (genvar i = 0; i < NCELL; i++) begin : g_link
    if ((i % CHAIN) == 0) begin : g_head
      assign cin[i] = 1'b0;
    end else begin : g_body
      assign cin[i] = carry[i-1];
    end

    assign total[i] = local_or[i] | cin[i];
    assign carry[i] = casc_fwd[i] & total[i];
    assign sum_o[i] = ~casc_fwd[i] & total[i];

    if ((((i + 1) % CHAIN) == 0) || (i == NCELL - 1)) begin : g_tail
      assign tail_unused[i] = carry[i];
    end else begin : g_mid
      assign tail_unused[i] = 1'b0;
    end
  end
endmodule

// File: rtl/plb_logic_block.sv
module plb_logic_block
  import plb_pkg::*;
#(
  parameter int NCELL = PLB_CELLS,
  parameter int NTERM = PLB_TERMS,
  parameter int NLINE = PLB_LINES,
  parameter int GW    = PLB_GLB_W,
  parameter int CHAIN = PLB_CHAIN,
  parameter int IW    = $clog2(GW),
  parameter int TW    = (NTERM > 1) ? $clog2(NTERM) : 1
) (
  input  logic [GW-1:0]                         glb_bus,
  input  logic [NLINE-1:0]                      sel_en,
  input  logic [NLINE-1:0][IW-1:0]              sel_idx,
  input  logic [NCELL-1:0][NTERM-1:0][NLINE-1:0] lt_use,
  input  logic [NCELL-1:0][NTERM-1:0][NLINE-1:0] lt_inv,
  input  logic [NCELL-1:0][NTERM-1:0][NCELL-1:0] rt_use,
  input  logic [NCELL-1:0][NTERM-1:0][NCELL-1:0] rt_inv,
  input  logic [NCELL-1:0][TW-1:0]              ret_sel,
  input  logic [NCELL-1:0]                      casc_fwd,
  output logic [NCELL-1:0]                      sum_o
);
  logic [NLINE-1:0]            lines;
  logic [NCELL-1:0]            ret_bus;
  logic [NCELL-1:0][NTERM-1:0] pterm;
  logic [NCELL-1:0]            local_or;

  plb_switch_matrix #(.GW(GW), .NLINE(NLINE), .IW(IW)) u_sw (
    .glb_bus (glb_bus),
    .sel_en  (sel_en),
    .sel_idx (sel_idx),
    .lines   (lines)
  );

  for (genvar c = 0; c < NCELL; c++) begin : g_cell
    plb_cell #(.NLINE(NLINE), .NRET(NCELL), .NTERM(NTERM), .TW(TW)) u_cell (
      .lines    (lines),
      .ret_bus  (ret_bus),
      .lt_use   (lt_use[c]),
      .lt_inv   (lt_inv[c]),
      .rt_use   (rt_use[c]),
      .rt_inv   (rt_inv[c]),
      .ret_sel  (ret_sel[c]),
      .pterm    (pterm[c]),
      .ret_o    (ret_bus[c]),
      .local_or (local_or[c])
    );
  end

  plb_cascade #(.NCELL(NCELL), .CHAIN(CHAIN)) u_casc (
    .local_or (local_or),
    .casc_fwd (casc_fwd),
    .sum_o    (sum_o)
  );
endmodule

// File: rtl/plb_logic_block_chk.sv
module plb_logic_block_chk #(
  parameter int NCELL = 16,
  parameter int NTERM = 5,
  parameter int NLINE = 40,
  parameter int CHAIN = 8,
  parameter int TW    = 3
) (
  input logic [NLINE-1:0]                       sel_en,
  input logic [NLINE-1:0]                       lines,
  input logic [NCELL-1:0][TW-1:0]               ret_sel,
  input logic [NCELL-1:0]                       ret_bus,
  input logic [NCELL-1:0][NTERM-1:0][NLINE-1:0] lt_use,
  input logic [NCELL-1:0][NTERM-1:0][NCELL-1:0] rt_use,
  input logic [NCELL-1:0][NTERM-1:0]            pterm,
  input logic [NCELL-1:0]                       local_or,
  input logic [NCELL-1:0]                       casc_fwd,
  input logic [NCELL-1:0]                       sum_o
);
  always_comb begin
    for (int k = 0; k < NLINE; k++) begin
      if (!sel_en[k]) begin
        a_r1_line_off: assert (lines[k] == 1'b0) else $error("disabled array line %0d not 0", k);
      end
    end
    for (int c = 0; c < NCELL; c++) begin
      for (int t = 0; t < NTERM; t++) begin
        if ((lt_use[c][t] == '0) && (rt_use[c][t] == '0)) begin
          a_r2_empty_term: assert (pterm[c][t] == 1'b0) else $error("empty term %0d/%0d not 0", c, t);
        end
      end
      if (local_or[c] && !casc_fwd[c]) begin
        a_r4_sum_covers: assert (sum_o[c]) else $error("cell %0d local term lost", c);
      end
      if (casc_fwd[c]) begin
        a_r5_donor_quiet: assert (!sum_o[c]) else $error("donor cell %0d drives its sum", c);
      end
      if (((c % CHAIN) == 0) && !casc_fwd[c]) begin
        a_r6_chain_head: assert (sum_o[c] == local_or[c]) else $error("group head %0d sees a carry", c);
      end
      if (int'(ret_sel[c]) >= NTERM) begin
        a_r8_ret_idle: assert (ret_bus[c]) else $error("idle return line %0d not 1", c);
      end
    end
  end
endmodule

bind plb_logic_block plb_logic_block_chk #(
  .NCELL(NCELL), .NTERM(NTERM), .NLINE(NLINE), .CHAIN(CHAIN), .TW(TW)
) u_chk (
  .sel_en   (sel_en),
  .lines    (lines),
  .ret_sel  (ret_sel),
  .ret_bus  (ret_bus),
  .lt_use   (lt_use),
  .rt_use   (rt_use),
  .pterm    (pterm),
  .local_or (local_or),
  .casc_fwd (casc_fwd),
  .sum_o    (sum_o)
);

// File: tb/tb_plb_logic_block.sv
`timescale 1ns/1ps
module tb_plb_logic_block;
  localparam int NCELL = 16;
  localparam int NTERM = 5;
  localparam int NLINE = 40;
  localparam int GW    = 64;
  localparam int IW    = 6;
  localparam int TW    = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [GW-1:0]                         glb_bus;
  logic [NLINE-1:0]                      sel_en;
  logic [NLINE-1:0][IW-1:0]              sel_idx;
  logic [NCELL-1:0][NTERM-1:0][NLINE-1:0] lt_use, lt_inv;
  logic [NCELL-1:0][NTERM-1:0][NCELL-1:0] rt_use, rt_inv;
  logic [NCELL-1:0][TW-1:0]              ret_sel;
  logic [NCELL-1:0]                      casc_fwd;
  logic [NCELL-1:0]                      sum_o;

  plb_logic_block dut (
    .glb_bus(glb_bus), .sel_en(sel_en), .sel_idx(sel_idx),
    .lt_use(lt_use), .lt_inv(lt_inv), .rt_use(rt_use), .rt_inv(rt_inv),
    .ret_sel(ret_sel), .casc_fwd(casc_fwd), .sum_o(sum_o)
  );

  int nvec = 0;
  int nbad = 0;
  bit done = 1'b0;

  // Entry: {g63, g8..g0, expected sum_o[7:0]}; sum_o[15:8] expected 0.
  localparam logic [17:0] VEC [12] = '{
    {10'h000, 8'h0A}, {10'h3FF, 8'hEF}, {10'h001, 8'h0A}, {10'h003, 8'h0B},
    {10'h004, 8'h08}, {10'h00C, 8'h0A}, {10'h200, 8'h0E}, {10'h010, 8'h2A},
    {10'h020, 8'h2A}, {10'h040, 8'h0A}, {10'h0C0, 8'hCA}, {10'h100, 8'h8A}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: sum_o=%h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [GW-1:0] g, input string req, input logic [15:0] exp);
    @(posedge clk);
    glb_bus = g;
    @(negedge clk);
    check(req, sum_o, exp);
  endtask

  task automatic clear_cfg();
    sel_en = '0; sel_idx = '0;
    lt_use = '0; lt_inv = '0; rt_use = '0; rt_inv = '0;
    ret_sel = '0; casc_fwd = '0;
  endtask

  task automatic identity_sel();
    for (int k = 0; k < NLINE; k++) begin
      sel_en[k] = 1'b1;
      sel_idx[k] = IW'(k);
    end
  endtask

  task automatic lit(input int c, input int t, input int l, input bit inv);
    lt_use[c][t][l] = 1'b1;
    lt_inv[c][t][l] = inv;
  endtask

  task automatic rlit(input int c, input int t, input int r, input bit inv);
    rt_use[c][t][r] = 1'b1;
    rt_inv[c][t][r] = inv;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: run hung");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    clear_cfg();
    glb_bus = '0;

    // R2: cleared configuration, every term empty, all sums 0.
    apply(64'hDEAD_BEEF_1234_5678, "R2 empty terms", 16'h0000);

    // Table configuration (R1 R3 R4 R5 R7).
    identity_sel();
    sel_en[38] = 1'b0; sel_idx[38] = 6'd0;
    sel_idx[39] = 6'd63;
    lit(0, 0, 0, 0); lit(0, 0, 1, 0);
    lit(1, 0, 2, 1); lit(1, 1, 3, 0);
    lit(2, 0, 39, 0);
    lit(3, 0, 38, 1);
    casc_fwd[4] = 1'b1; lit(4, 0, 4, 0);
    lit(5, 0, 5, 0);
    lit(6, 0, 6, 0); lit(6, 0, 7, 0); ret_sel[6] = 3'd0;
    rlit(7, 0, 6, 1); lit(7, 1, 8, 0);
    for (int i = 0; i < 12; i++) begin
      logic [GW-1:0] g;
      g = 64'h0000_00A5_A5F0_0E00;
      g[8:0] = VEC[i][16:8];
      g[63]  = VEC[i][17];
      apply(g, "R1 R3 R4 R5 R7 table", {8'h00, VEC[i][7:0]});
    end

    // R6 and R4: 40-term chain over cells 8..15, single bit walked over all lines.
    clear_cfg();
    identity_sel();
    for (int k = 0; k < 8; k++) begin
      for (int t = 0; t < NTERM; t++) lit(8 + k, t, k * 5 + t, 0);
      if (k < 7) casc_fwd[8 + k] = 1'b1;
    end
    apply('0, "R6 chain idle", 16'h0000);
    for (int b = 0; b < NLINE; b++) begin
      apply(64'd1 << b, "R6 r4_ 40-term chain", 16'h8000);
    end

    // R6 and R5: forwarding out of group-final cells is dropped.
    clear_cfg();
    identity_sel();
    casc_fwd[7] = 1'b1; lit(7, 0, 0, 0);
    casc_fwd[15] = 1'b1; lit(15, 0, 1, 0);
    apply(64'h3, "R6 boundary drop", 16'h0000);

    // R3 and R7: all sixteen return lines feed cell 0 term 1.
    clear_cfg();
    identity_sel();
    for (int j = 0; j < NCELL; j++) begin
      lit(j, 0, j, 0);
      rlit(0, 1, j, 0);
    end
    apply('0,            "R3 all returns high", 16'h0001);
    apply(64'h0000_0020, "R3 one return low",   16'h0020);
    apply(64'h0000_0001, "R3 own term",         16'h0001);
    apply(64'h0000_8000, "R3 top return low",   16'h8000);

    // R7: return line built from array-line literals only.
    clear_cfg();
    identity_sel();
    lit(3, 0, 3, 0);
    lit(2, 1, 20, 0); rlit(2, 1, 3, 0); ret_sel[2] = 3'd1;
    rlit(4, 0, 2, 1);
    apply(64'h0010_0008, "R7 return ignores return literal", 16'h0018);
    apply(64'h0000_0008, "R7 return follows line part",     16'h0008);

    // R8: out-of-range return select idles high.
    clear_cfg();
    rlit(1, 0, 0, 0);
    ret_sel[0] = 3'd7;
    apply('0, "R8 select 7 idle", 16'h0002);
    ret_sel[0] = 3'd5;
    apply('0, "R8 select 5 idle", 16'h0002);
    ret_sel[0] = 3'd0;
    apply('0, "R8 select 0 active", 16'h0000);

    // R1: disabled line forced 0; enabled line follows its index.
    clear_cfg();
    sel_en[0] = 1'b0; sel_idx[0] = 6'd5;
    lit(0, 0, 0, 1);
    apply('1, "R1 disabled line", 16'h0001);
    lt_inv = '0;
    sel_en[0] = 1'b1; sel_idx[0] = 6'd63;
    apply(64'h8000_0000_0000_0000, "R1 index 63 high", 16'h0001);
    apply(64'h0000_0000_0000_0001, "R1 index 63 low",  16'h0000);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule